// File: doc/BRIEF.md
# Conversion and Clock Burst Sequencer

This block sits on the host side of a serial analog-to-digital converter whose data link carries its own timing. On request it raises a conversion-start pulse of a fixed width. It then waits out the worst-case delay before the converter's first header bit can appear. After that it drives a gated serial clock made of a fixed number of pulses, and it tells the local receiver, with a one-cycle start strobe, that the burst has begun. Between bursts the serial clock stays low.

All timing is counted in system clock cycles, and the serial clock runs at half the system rate. A frame normally needs 18 clock pulses. A legacy mode adds one leading zero bit, so the frame needs 19 pulses. The mode is sampled when a conversion is accepted. Each burst has to end before a deadline that falls a set number of cycles into the following conversion. When the selected mode cannot meet that deadline, the sequencer skips the burst and the receiver strobe for that frame and raises a one-cycle overrun flag instead. Parameter sets that break basic ordering stop elaboration. Examples are a first-bit delay that does not fit inside the period, or a deadline that lies past the next frame's first-bit point.

Top module: `cnv_burst_seq`

## Requirements
- R1: While reset is asserted, and after it, until a request is accepted, `cnv_o`, `sclk_o`, `rx_start_o` and `overrun_o` are all low. Asserting reset during a burst clears all four outputs at once.
- R2: A high `conv_req_i` sampled while idle makes `cnv_o` high from the next cycle (cycle 0 of the frame) for exactly `PULSE_W` cycles, and then low.
- R3: Requests that arrive during the `CONV_PERIOD` cycles of a running conversion are ignored. A request held high starts the next conversion exactly `CONV_PERIOD` cycles after the previous one.
- R4: The first serial clock pulse goes high in frame cycle `FIRST_BIT_LAT`, and `sclk_o` is never high earlier in the frame.
- R5: In standard mode (`legacy_i` = 0 at acceptance) the burst has exactly `FRAME_BITS` (18) pulses. Each pulse is high for one cycle and low for the next, which is the system clock divided by 2.
- R6: In legacy mode (`legacy_i` = 1 at acceptance) the burst has `FRAME_BITS + LEGACY_EXTRA` (19) pulses, but only when the burst fits before the deadline.
- R7: `rx_start_o` is a single-cycle pulse. It is high in the same cycle as the first high phase of `sclk_o`.
- R8: When `FIRST_BIT_LAT + 2*pulses > CONV_PERIOD + DEADLINE` for the latched mode, no serial clock and no `rx_start_o` are produced for that frame. Instead `overrun_o` pulses for one cycle in frame cycle `FIRST_BIT_LAT`. With the default parameters, legacy mode overruns.
- R9: Every burst that is emitted has its last high phase before frame cycle `CONV_PERIOD + DEADLINE`.
- R10: Changing `legacy_i` after a conversion has been accepted has no effect on that frame's pulse count or overrun result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_req_i | input | 1 | Request to start a conversion |
| legacy_i | input | 1 | 1 selects the frame with the extra leading zero bit |
| cnv_o | output | 1 | Conversion-start pulse to the converter |
| sclk_o | output | 1 | Gated serial clock burst (system clock divided by 2) |
| rx_start_o | output | 1 | One-cycle strobe to the receiver at the start of the burst |
| overrun_o | output | 1 | One-cycle flag when a frame's burst cannot meet its deadline |

## Verification
The checker watches, on every cycle, the bound on conversion-pulse width, the position of the receiver strobe relative to conversion start and to the serial clock, the exclusion between overrun and burst activity, and a ceiling on the pulse count per frame. Other properties need whole scenarios, and only the bench shows them. These are the exact pulse counts in each mode, the alternating half-rate shape, the deadline margin, the ignored and back-to-back requests, the mode being latched when a conversion is accepted, and recovery from a reset during a burst.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    LAUNCH_NONE    = 2'd0,
    LAUNCH_BURST   = 2'd1,
    LAUNCH_OVERRUN = 2'd2
  } launch_e;

  // True when a burst of nbits half-rate pulses that starts at frame cycle
  // lat still ends before frame cycle (period + deadline).
  function automatic bit burst_fits(input int lat, input int nbits,
                                    input int period, input int deadline);
    return (lat + 2 * nbits) <= (period + deadline);
  endfunction

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/seq_conv_timer.sv
module seq_conv_timer #(
  parameter int PULSE_W       = 2,
  parameter int CONV_PERIOD   = 40,
  parameter int FIRST_BIT_LAT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic mode_i,
  output logic cnv_o,
  output logic launch_o,
  output logic mode_o
);

  localparam int CW = $clog2(CONV_PERIOD + 1);
  localparam logic [CW-1:0] LAST_CNT   = CW'(CONV_PERIOD - 1);
  localparam logic [CW-1:0] LAUNCH_CNT = CW'(FIRST_BIT_LAT - 1);
  localparam logic [CW-1:0] PW         = CW'(PULSE_W);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnv_q, cnv_d;
  logic          mode_q, mode_d;
  logic          accept;
  logic          cnt_en;
  logic          mode_en;

  // A request is taken when idle, or on the last cycle of a running period
  // so that a held request repeats with an exact period.
  assign accept  = req_i && (!busy_q || (cnt_q == LAST_CNT));
  assign cnt_en  = accept || busy_q;
  assign mode_en = accept;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnv_d  = 1'b0;
    mode_d = mode_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      cnv_d  = 1'b1;
      mode_d = mode_i;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      cnv_d = (cnt_q + 1'b1) < PW;
      if (cnt_q == LAST_CNT) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cnv_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnv_q  <= cnv_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (mode_en) mode_q <= mode_d;
    end
  end

  assign cnv_o    = cnv_q;
  assign launch_o = busy_q && (cnt_q == LAUNCH_CNT);
  assign mode_o   = mode_q;

endmodule

// File: rtl/seq_burst_gen.sv
module seq_burst_gen
  import seq_pkg::*;
#(
  parameter int NBITS_STD = 18,
  parameter int NBITS_LEG = 19,
  parameter bit FIT_STD   = 1'b1,
  parameter bit FIT_LEG   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic legacy_i,
  output logic sclk_o,
  output logic rx_start_o,
  output logic overrun_o
);

  localparam int NMAX = (NBITS_LEG > NBITS_STD) ? NBITS_LEG : NBITS_STD;
  localparam int HW   = $clog2(2 * NMAX);
  localparam logic [HW-1:0] LIM_STD = HW'(2 * NBITS_STD - 1);
  localparam logic [HW-1:0] LIM_LEG = HW'(2 * NBITS_LEG - 1);

  logic          active_q, active_d;
  logic [HW-1:0] half_q, half_d;
  logic [HW-1:0] lim_q, lim_d;
  logic          sclk_q, sclk_d;
  logic          rx_q, rx_d;
  logic          ov_q, ov_d;
  logic          half_en;
  launch_e       outcome;

  always_comb begin
    outcome = LAUNCH_NONE;
    if (launch_i && !active_q) begin
      if (legacy_i ? FIT_LEG : FIT_STD) outcome = LAUNCH_BURST;
      else                              outcome = LAUNCH_OVERRUN;
    end
  end

  assign half_en = active_q || (outcome == LAUNCH_BURST);

  always_comb begin
    active_d = active_q;
    half_d   = half_q;
    lim_d    = lim_q;
    sclk_d   = 1'b0;
    rx_d     = 1'b0;
    ov_d     = 1'b0;
    case (outcome)
      LAUNCH_BURST: begin
        active_d = 1'b1;
        half_d   = '0;
        lim_d    = legacy_i ? LIM_LEG : LIM_STD;
        sclk_d   = 1'b1;
        rx_d     = 1'b1;
      end
      LAUNCH_OVERRUN: ov_d = 1'b1;
      default: begin
        if (active_q) begin
          if (half_q == lim_q) begin
            active_d = 1'b0;
          end else begin
            half_d = half_q + 1'b1;
            // even half index is the high phase
            sclk_d = half_q[0];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      half_q   <= '0;
      lim_q    <= '0;
      sclk_q   <= 1'b0;
      rx_q     <= 1'b0;
      ov_q     <= 1'b0;
    end else begin
      active_q <= active_d;
      sclk_q   <= sclk_d;
      rx_q     <= rx_d;
      ov_q     <= ov_d;
      if (half_en) begin
        half_q <= half_d;
        lim_q  <= lim_d;
      end
    end
  end

  assign sclk_o     = sclk_q;
  assign rx_start_o = rx_q;
  assign overrun_o  = ov_q;

endmodule

// File: rtl/cnv_burst_seq.sv
module cnv_burst_seq
  import seq_pkg::*;
#(
  parameter int PULSE_W       = 2,
  parameter int FIRST_BIT_LAT = 10,
  parameter int CONV_PERIOD   = 40,
  parameter int DEADLINE      = 7,
  parameter int FRAME_BITS    = 18,
  parameter int LEGACY_EXTRA  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_req_i,
  input  logic legacy_i,
  output logic cnv_o,
  output logic sclk_o,
  output logic rx_start_o,
  output logic overrun_o
);

  localparam int NBITS_LEG = FRAME_BITS + LEGACY_EXTRA;
  localparam bit FIT_STD   = burst_fits(FIRST_BIT_LAT, FRAME_BITS, CONV_PERIOD, DEADLINE);
  localparam bit FIT_LEG   = burst_fits(FIRST_BIT_LAT, NBITS_LEG, CONV_PERIOD, DEADLINE);

  generate
    if (PULSE_W < 1 || PULSE_W >= CONV_PERIOD || FIRST_BIT_LAT < 1 ||
        FIRST_BIT_LAT >= CONV_PERIOD || DEADLINE < 0 || DEADLINE > FIRST_BIT_LAT ||
        FRAME_BITS < 1 || LEGACY_EXTRA < 0) begin : g_bad_cfg
      $error("cnv_burst_seq: inconsistent timing parameters");
    end
  endgenerate

  logic rst_n_s;
  logic launch;
  logic mode_latched;

  seq_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  seq_conv_timer #(
    .PULSE_W       (PULSE_W),
    .CONV_PERIOD   (CONV_PERIOD),
    .FIRST_BIT_LAT (FIRST_BIT_LAT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .req_i    (conv_req_i),
    .mode_i   (legacy_i),
    .cnv_o    (cnv_o),
    .launch_o (launch),
    .mode_o   (mode_latched)
  );

  seq_burst_gen #(
    .NBITS_STD (FRAME_BITS),
    .NBITS_LEG (NBITS_LEG),
    .FIT_STD   (FIT_STD),
    .FIT_LEG   (FIT_LEG)
  ) u_burst (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .launch_i   (launch),
    .legacy_i   (mode_latched),
    .sclk_o     (sclk_o),
    .rx_start_o (rx_start_o),
    .overrun_o  (overrun_o)
  );

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int PULSE_W       = 2,
  parameter int FIRST_BIT_LAT = 10,
  parameter int CONV_PERIOD   = 40,
  parameter int DEADLINE      = 7,
  parameter int FRAME_BITS    = 18,
  parameter int LEGACY_EXTRA  = 1
) (
  input logic clk,
  input logic rst_n,
  input logic cnv_o,
  input logic sclk_o,
  input logic rx_start_o,
  input logic overrun_o
);

  localparam int NMAX = FRAME_BITS + LEGACY_EXTRA;
  localparam int HCW  = $clog2(CONV_PERIOD + 1);
  localparam int SW   = $clog2(CONV_PERIOD + DEADLINE + 2);
  localparam int RCW  = $clog2(NMAX + 2);

  logic [HCW-1:0] hi_cnt;
  logic [SW-1:0]  since_q;
  logic [RCW-1:0] rise_cnt;
  logic           cnv_prev, sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= '0;
      since_q   <= '0;
      rise_cnt  <= '0;
      cnv_prev  <= 1'b0;
      sclk_prev <= 1'b0;
    end else begin
      cnv_prev  <= cnv_o;
      sclk_prev <= sclk_o;
      if (!cnv_o)                     hi_cnt <= '0;
      else if (hi_cnt != '1)          hi_cnt <= hi_cnt + 1'b1;
      if (cnv_o && !cnv_prev)         since_q <= SW'(1);
      else if (since_q != '1)         since_q <= since_q + 1'b1;
      if (rx_start_o)                 rise_cnt <= RCW'(1);
      else if (sclk_o && !sclk_prev && rise_cnt != '1) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R2: start pulse never exceeds its width
  a_r2_cnv_width: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o |-> (hi_cnt < HCW'(PULSE_W)));

  // R4: receiver strobe sits exactly at the first-bit latency
  a_r4_first_bit_point: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start_o |-> (since_q == SW'(FIRST_BIT_LAT)));

  // R7: strobe coincides with a clock high phase and lasts one cycle
  a_r7_strobe_on_clock: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start_o |-> (sclk_o && !sclk_prev));

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start_o |=> !rx_start_o);

  // R8: overrun excludes burst activity
  a_r8_overrun_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> (!sclk_o && !rx_start_o));

  // R5/R6: no burst carries more than the legacy pulse count
  a_r6_pulse_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && !sclk_prev && !rx_start_o) |-> (rise_cnt < RCW'(NMAX)));

endmodule

bind cnv_burst_seq seq_checker #(
  .PULSE_W       (PULSE_W),
  .FIRST_BIT_LAT (FIRST_BIT_LAT),
  .CONV_PERIOD   (CONV_PERIOD),
  .DEADLINE      (DEADLINE),
  .FRAME_BITS    (FRAME_BITS),
  .LEGACY_EXTRA  (LEGACY_EXTRA)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnv_o      (cnv_o),
  .sclk_o     (sclk_o),
  .rx_start_o (rx_start_o),
  .overrun_o  (overrun_o)
);

// File: tb/sim_cnv_burst_seq.sv
module sim_cnv_burst_seq;

  localparam int CLK_PERIOD = 10;
  localparam int PW   = 2;
  localparam int LAT  = 10;
  localparam int PER  = 40;
  localparam int DL   = 7;
  localparam int WIN  = PER + DL + 4;

  typedef struct packed {
    logic       leg;
    logic [7:0] req_len;
    logic [4:0] n_exp;
    logic       ov_exp;
  } vec_t;

  // default parameters: 18 pulses fit (10+36 <= 47), 19 do not (10+38 > 47)
  localparam vec_t VEC [0:4] = '{
    '{1'b0, 8'd1,  5'd18, 1'b0},
    '{1'b1, 8'd1,  5'd0,  1'b1},
    '{1'b0, 8'd6,  5'd18, 1'b0},
    '{1'b1, 8'd30, 5'd0,  1'b1},
    '{1'b0, 8'd39, 5'd18, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic conv_req_i, legacy_i;
  logic cnv_o, sclk_o, rx_start_o, overrun_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int cnv_hi, cnv_at0, rise2, s_first, s_last, s_rises, pat_err;
  int rx_cnt, rx_idx, ov_cnt, ov_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnv_burst_seq u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_req_i (conv_req_i),
    .legacy_i   (legacy_i),
    .cnv_o      (cnv_o),
    .sclk_o     (sclk_o),
    .rx_start_o (rx_start_o),
    .overrun_o  (overrun_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Starts one frame and records output activity per frame cycle.
  task automatic run_frame(input logic leg, input int req_len,
                           input int mid_req_at, input logic leg_flip);
    logic s [0:WIN-1];
    logic cprev;
    cnv_hi = 0; cnv_at0 = 0; rise2 = -1; s_first = -1; s_last = -1;
    s_rises = 0; pat_err = 0; rx_cnt = 0; rx_idx = -1; ov_cnt = 0; ov_idx = -1;
    cprev = 1'b0;
    @(negedge clk);
    conv_req_i = 1'b1;
    legacy_i   = leg;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      s[i] = sclk_o;
      if (i == 0) cnv_at0 = int'(cnv_o);
      if (cnv_o && i < PER) cnv_hi++;
      if (cnv_o && !cprev && i > 0 && rise2 < 0) rise2 = i;
      cprev = cnv_o;
      if (i < PER + DL) begin
        if (sclk_o) begin
          if (s_first < 0) s_first = i;
          s_last = i;
          if (i == 0 || !s[i-1]) s_rises++;
        end
        if (rx_start_o) begin rx_cnt++; rx_idx = i; end
        if (overrun_o)  begin ov_cnt++; ov_idx = i; end
      end
      conv_req_i = (i + 1 < req_len) || (i == mid_req_at);
      legacy_i   = leg_flip ? ~leg : leg;
    end
    conv_req_i = 1'b0;
    if (s_first >= 0)
      for (int i = s_first; i <= s_last; i++)
        if (s[i] != ((i - s_first) % 2 == 0)) pat_err++;
  endtask

  task automatic check_frame(input int n, input bit ov, input string tag);
    chk({tag, " R2 cnv in cycle 0"}, cnv_at0, 1);
    chk({tag, " R2 cnv width"}, cnv_hi, PW);
    chk({tag, " R5/R6 pulse count"}, s_rises, n);
    chk({tag, " R4 first sclk cycle"}, s_first, (n > 0) ? LAT : -1);
    chk({tag, " R7 rx_start count"}, rx_cnt, (n > 0) ? 1 : 0);
    chk({tag, " R8 overrun count"}, ov_cnt, ov ? 1 : 0);
    if (n > 0) begin
      chk({tag, " R5 half-rate shape"}, pat_err, 0);
      chk({tag, " R5 burst span"}, s_last - s_first, 2 * n - 2);
      chk({tag, " R7 rx_start cycle"}, rx_idx, LAT);
      chk({tag, " R9 before deadline"}, int'(s_last < PER + DL), 1);
    end
    if (ov) chk({tag, " R8 overrun cycle"}, ov_idx, LAT);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; conv_req_i = 1'b0; legacy_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs", int'({cnv_o, sclk_o, rx_start_o, overrun_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle outputs", int'({cnv_o, sclk_o, rx_start_o, overrun_o}), 0);

    // table of vectors
    for (int v = 0; v < 5; v++) begin
      run_frame(VEC[v].leg, int'(VEC[v].req_len), -1, 1'b0);
      check_frame(int'(VEC[v].n_exp), VEC[v].ov_exp, $sformatf("vec%0d", v));
      chk($sformatf("vec%0d R3 no second start", v), rise2, -1);
    end

    // R3: request in the middle of a conversion is ignored
    run_frame(1'b0, 1, 5, 1'b0);
    check_frame(18, 1'b0, "mid-request");
    chk("R3 mid request ignored", rise2, -1);

    // R3: held request repeats with exact period
    run_frame(1'b0, 1000, -1, 1'b0);
    chk("R3 held period", rise2, PER);
    repeat (2 * PER) @(negedge clk);

    // R10: mode flips after acceptance have no effect
    run_frame(1'b0, 1, -1, 1'b1);
    check_frame(18, 1'b0, "R10 std->leg");
    run_frame(1'b1, 1, -1, 1'b1);
    check_frame(0, 1'b1, "R10 leg->std");

    // R1: reset in the middle of a burst
    @(negedge clk);
    conv_req_i = 1'b1; legacy_i = 1'b0;
    @(negedge clk);
    conv_req_i = 1'b0;
    repeat (LAT + 5) @(negedge clk);
    rst_n = 1'b0;
    #(CLK_PERIOD/4);
    chk("R1 reset during burst", int'({cnv_o, sclk_o, rx_start_o, overrun_o}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 quiet after reset", int'({cnv_o, sclk_o, rx_start_o, overrun_o}), 0);
    run_frame(1'b0, 1, -1, 1'b0);
    check_frame(18, 1'b0, "R1 recovery");

    summary();
  end

endmodule